// File: doc/BRIEF.md
# I2C Clock Waveform Generator

This block produces the SCL waveform for an I2C master from a single 24-bit timing word. The word carries a low-period divider, a high-speed divider that this block leaves unused, and an optional separate high-period divider. Each SCL half lasts its divider plus a fixed overhead of three source-clock cycles. If the high-period field is zero, both halves use the low divider, which gives a symmetric waveform for standard mode. If the high-period field is non-zero, the high half uses that field instead. Software sets it to about half the low divider for fast and fast-plus rates, which gives roughly one third high and two thirds low.

The SCL output is open drain: the block either pulls the line low or releases it. A sampled copy of the real line comes back in. While the block has released SCL, a low reading on that input means a target is stretching the clock, and the high-phase count is frozen until the line rises. A bit-level engine above this block uses the one-cycle rise and fall strobes to time data changes and sampling. Deasserting enable releases the line and returns the block to idle. START/STOP generation, data shifting and high-speed mode are handled elsewhere.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is held, and right after it, SCL is released (sclDriveLow = 0) and neither strobe is asserted.
- R2: While enable is low, SCL stays released and neither strobe fires. If enable drops during the low half, the line is released on the next cycle and sclRise pulses in that same cycle.
- R3: When enable is seen high at a clock edge while the block is idle, that edge starts a low half: sclDriveLow goes to 1 and sclFall pulses in the same cycle.
- R4: The low half lasts ctrlWord[7:0] + 3 clock cycles (3 cycles when the field is 0, 258 cycles when it is 255).
- R5: When ctrlWord[23:16] is zero, the high half lasts ctrlWord[7:0] + 3 cycles.
- R6: When ctrlWord[23:16] is non-zero, the high half lasts ctrlWord[23:16] + 3 cycles.
- R7: ctrlWord[15:8] has no effect on timing, even if it changes while the clock is running.
- R8: During the high half, every cycle in which sclIn reads low freezes the count, so the high half grows by exactly that many cycles.
- R9: sclRise and sclFall each last one cycle, never fire together, and coincide with the cycle in which sclDriveLow changes (rise: 1 to 0, fall: 0 to 1).
- R10: If enable drops during the high half, the line stays released with no strobe. The next enable starts again with a fresh low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL waveform; low releases SCL and idles |
| ctrlWord | input | 24 | [7:0] low divider, [15:8] high-speed divider (unused), [23:16] high divider |
| sclIn | input | 1 | Sampled SCL line level, used to detect clock stretching |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sclRise | output | 1 | One-cycle pulse in the first cycle SCL is released |
| sclFall | output | 1 | One-cycle pulse in the first cycle SCL is pulled low |

## Verification
A corrupted half-period count shows up at the ports within one SCL half: the next rise or fall strobe moves by the error. The reference model catches this in the cycle where the strobe should have fired. A phase register stuck in the wrong state breaks the link between sclDriveLow and the strobes on the very next cycle. A stretch hold that is missing, or held too long, shifts the next fall by the number of stretched cycles. The bench measures whole low and high lengths after each strobe, so an error too small to see in one cycle still changes the next measured length.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  // Command from the phase controller to the count path
  typedef struct packed {
    logic clear;    // restart the half-period count at zero
    logic advance;  // count one more cycle of the current half
    logic selHigh;  // compare against the high-half length
  } cntCmd_t;

endpackage

// File: rtl/scl_cnt_path.sv
module scl_cnt_path
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int OVERHEAD   = 3,
  parameter bit SPLIT_HIGH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3*FIELD_W-1:0] ctrlWord,
  input  cntCmd_t              cmd,
  output logic                 cntDone
);

  localparam int CNT_W = FIELD_W + 2;

  logic [FIELD_W-1:0] lowDiv;
  logic [FIELD_W-1:0] speedDiv;
  logic [FIELD_W-1:0] highField;
  logic [FIELD_W-1:0] highDiv;
  logic [CNT_W-1:0]   lowLast;
  logic [CNT_W-1:0]   highLast;
  logic [CNT_W-1:0]   target;
  logic [CNT_W-1:0]   cnt;

  assign lowDiv    = ctrlWord[FIELD_W-1:0];
  assign speedDiv  = ctrlWord[2*FIELD_W-1:FIELD_W];
  assign highField = ctrlWord[3*FIELD_W-1:2*FIELD_W];

  generate
    if (SPLIT_HIGH) begin : g_splitHigh
      // a non-zero high field selects the asymmetric waveform
      assign highDiv = (highField != '0) ? highField : lowDiv;
    end else begin : g_symHigh
      assign highDiv = lowDiv;
    end
  endgenerate

  // last count value of each half: divider + overhead - 1
  assign lowLast  = CNT_W'(lowDiv)  + CNT_W'(OVERHEAD - 1);
  assign highLast = CNT_W'(highDiv) + CNT_W'(OVERHEAD - 1);
  assign target   = cmd.selHigh ? highLast : lowLast;
  assign cntDone  = (cnt == target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.clear) begin
      cnt <= '0;
    end else if (cmd.advance) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4/R6: a cleared count starts the new half at zero
  a_r4_clear_restarts: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clear |=> (cnt == '0));

  // R8: with no command the count is frozen
  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clear && !cmd.advance) |=> $stable(cnt));

  // R7: a change in the speed field alone leaves the terminal flag unchanged
  a_r7_speed_inert: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(speedDiv) && $stable(lowDiv) && $stable(highField) &&
     $stable(cmd) && $past(!cmd.clear && !cmd.advance)) |-> $stable(cntDone));

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclIn,
  input  logic    cntDone,
  output cntCmd_t cmd,
  output logic    sclDriveLow,
  output logic    sclRise,
  output logic    sclFall
);

  phase_t  phase;
  phase_t  phaseNext;
  logic    riseNext;
  logic    fallNext;
  cntCmd_t cmdC;

  always_comb begin
    phaseNext    = phase;
    riseNext     = 1'b0;
    fallNext     = 1'b0;
    cmdC         = '0;
    cmdC.selHigh = (phase == PH_HIGH);
    unique case (phase)
      PH_IDLE: begin
        cmdC.clear = 1'b1;
        if (enable) begin
          phaseNext = PH_LOW;
          fallNext  = 1'b1;
        end
      end
      PH_LOW: begin
        if (!enable) begin
          phaseNext  = PH_IDLE;
          riseNext   = 1'b1;
          cmdC.clear = 1'b1;
        end else if (cntDone) begin
          phaseNext  = PH_HIGH;
          riseNext   = 1'b1;
          cmdC.clear = 1'b1;
        end else begin
          cmdC.advance = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!enable) begin
          phaseNext  = PH_IDLE;
          cmdC.clear = 1'b1;
        end else if (!sclIn) begin
          // line held low by a target: freeze the high count
          phaseNext = PH_HIGH;
        end else if (cntDone) begin
          phaseNext  = PH_LOW;
          fallNext   = 1'b1;
          cmdC.clear = 1'b1;
        end else begin
          cmdC.advance = 1'b1;
        end
      end
      default: begin
        phaseNext  = PH_IDLE;
        cmdC.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      sclRise <= 1'b0;
      sclFall <= 1'b0;
    end else begin
      phase   <= phaseNext;
      sclRise <= riseNext;
      sclFall <= fallNext;
    end
  end

  assign cmd         = cmdC;
  assign sclDriveLow = (phase == PH_LOW);

  // R9: strobes are mutually exclusive
  a_r9_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sclRise && sclFall));

  // R9: rise strobe marks the release of the line
  a_r9_rise_at_release: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |-> (!sclDriveLow && $past(sclDriveLow)));

  // R9: fall strobe marks the pull-down of the line
  a_r9_fall_at_pull: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |-> (sclDriveLow && !$past(sclDriveLow)));

  // R2: disabling always releases the line with no fall strobe
  a_r2_disable_release: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !sclFall));

  // R3: enabling from idle starts with a low half
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && enable) |=> sclFall);

  // R8: a stretched line keeps the high half going
  a_r8_stretch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && enable && !sclIn) |=> (phase == PH_HIGH && !sclFall));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int OVERHEAD   = 3,
  parameter bit SPLIT_HIGH = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [3*FIELD_W-1:0] ctrlWord,
  input  logic                 sclIn,
  output logic                 sclDriveLow,
  output logic                 sclRise,
  output logic                 sclFall
);

  cntCmd_t cmd;
  logic    cntDone;

  scl_phase_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sclIn       (sclIn),
    .cntDone     (cntDone),
    .cmd         (cmd),
    .sclDriveLow (sclDriveLow),
    .sclRise     (sclRise),
    .sclFall     (sclFall)
  );

  scl_cnt_path #(
    .FIELD_W    (FIELD_W),
    .OVERHEAD   (OVERHEAD),
    .SPLIT_HIGH (SPLIT_HIGH)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWord (ctrlWord),
    .cmd      (cmd),
    .cntDone  (cntDone)
  );

  // R1: nothing is driven or strobed while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!sclDriveLow && !sclRise && !sclFall));

endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        stretchReq = 1'b0;
  logic [23:0] ctrlWord = '0;
  logic        sclLine;
  logic        sclDriveLow;
  logic        sclRise;
  logic        sclFall;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  // open-drain line: low if the block pulls or a target stretches
  assign sclLine = !sclDriveLow && !stretchReq;

  scl_timing_gen dut (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .ctrlWord    (ctrlWord),
    .sclIn       (sclLine),
    .sclDriveLow (sclDriveLow),
    .sclRise     (sclRise),
    .sclFall     (sclFall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int refPh  = 0;   // 0 idle, 1 low, 2 high
  int refRem = 0;   // cycles still to go in current half after this one
  bit eRise  = 0;
  bit eFall  = 0;

  function automatic int lowLen();
    return int'(ctrlWord[7:0]) + 3;
  endfunction

  function automatic int highLen();
    if (ctrlWord[23:16] != 0) return int'(ctrlWord[23:16]) + 3;
    return int'(ctrlWord[7:0]) + 3;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPh = 0; refRem = 0; eRise = 0; eFall = 0;
    end else begin
      eRise = 0; eFall = 0;
      if (!enable) begin
        if (refPh == 1) eRise = 1;
        refPh = 0;
      end else if (refPh == 0) begin
        refPh = 1; refRem = lowLen() - 1; eFall = 1;
      end else if (refPh == 1) begin
        if (refRem == 0) begin
          refPh = 2; refRem = highLen() - 1; eRise = 1;
        end else refRem--;
      end else begin
        if (stretchReq) begin
          // target holds the released line low: no progress
        end else if (refRem == 0) begin
          refPh = 1; refRem = lowLen() - 1; eFall = 1;
        end else refRem--;
      end
    end
  end

  // ---------------- per-cycle compare and length monitor ----------------
  int lowRun = 0, highRun = 0, lastLow = 0, lastHigh = 0;

  always @(negedge clk) begin
    check(sclDriveLow == (refPh == 1), "R4/R5/R6/R8 drive level", sclDriveLow, refPh == 1);
    check(sclRise == eRise, "R9 rise strobe", sclRise, eRise);
    check(sclFall == eFall, "R9 fall strobe", sclFall, eFall);
    if (sclFall) begin
      lastHigh = highRun; lowRun = 1;
    end else if (sclRise) begin
      lastLow = lowRun; highRun = 1;
    end else if (sclDriveLow) lowRun++;
    else highRun++;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic startRun(input logic [23:0] word);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    ctrlWord = word;
    enable = 1'b1;
  endtask

  // ---------------- directed scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    check(sclDriveLow == 0, "R1 released in reset", sclDriveLow, 0);
    check(!sclRise && !sclFall, "R1 no strobe in reset", sclRise | sclFall, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclDriveLow == 0, "R1 released after reset", sclDriveLow, 0);

    // symmetric waveform, 8-cycle halves
    ctrlWord = 24'h000305;
    enable = 1'b1;
    @(negedge clk);
    check(sclFall == 1 && sclDriveLow == 1, "R3 start with low half", sclFall, 1);
    repeat (50) @(negedge clk);
    check(lastLow == 8, "R4 low length", lastLow, 8);
    check(lastHigh == 8, "R5 symmetric high length", lastHigh, 8);

    // disable while low
    while (!sclDriveLow) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sclRise == 1 && sclDriveLow == 0, "R2 release on disable in low", sclRise, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!sclDriveLow && !sclRise && !sclFall, "R2 idle while disabled",
            sclDriveLow | sclRise | sclFall, 0);
    end

    // asymmetric waveform
    startRun(24'h04030A);
    repeat (60) @(negedge clk);
    check(lastLow == 13, "R6 low length asym", lastLow, 13);
    check(lastHigh == 7, "R6 high length from high field", lastHigh, 7);

    // disable while high
    @(negedge clk);
    while (!sclRise) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!sclDriveLow && !sclRise && !sclFall, "R10 disable in high is quiet",
          sclDriveLow | sclRise | sclFall, 0);
    enable = 1'b1;
    @(negedge clk);
    check(sclFall == 1 && sclDriveLow == 1, "R10 restart with low half", sclFall, 1);

    // minimum dividers
    startRun(24'h000000);
    repeat (30) @(negedge clk);
    check(lastLow == 3, "R4 minimum low", lastLow, 3);
    check(lastHigh == 3, "R5 minimum high", lastHigh, 3);

    // speed field ignored, changed mid-run
    startRun(24'h00FF06);
    repeat (30) @(negedge clk);
    ctrlWord[15:8] = 8'h11;
    repeat (40) @(negedge clk);
    check(lastLow == 9, "R7 low unaffected by speed field", lastLow, 9);
    check(lastHigh == 9, "R7 high unaffected by speed field", lastHigh, 9);

    // clock stretching
    startRun(24'h000304);
    repeat (20) @(negedge clk);
    while (!sclRise) @(negedge clk);
    stretchReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(sclDriveLow == 0 && sclFall == 0, "R8 stays high while stretched", sclDriveLow, 0);
    end
    stretchReq = 1'b0;
    while (!sclFall) @(negedge clk);
    @(posedge clk);
    check(lastHigh == 13, "R8 high extended by stretch", lastHigh, 13);

    // maximum low divider
    startRun(24'h0000FF);
    repeat (600) @(negedge clk);
    check(lastLow == 258, "R4 maximum low", lastLow, 258);
    check(lastHigh == 258, "R5 maximum high", lastHigh, 258);

    enable = 1'b0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule